// File: doc/BRIEF.md
# Normalizing Barrel Shifter

This block shifts a 16-bit operand into a 32-bit result field and is built for fixed-point work in both multiword and block floating-point formats. A single operation select chooses among five operations:

- a logical shift by a signed count;
- an arithmetic shift by a signed count;
- a normalize step, which uses a stored exponent to shift out redundant sign bits;
- a denormalize step, which uses the same stored exponent to move a value back to its fixed-point alignment;
- an exponent derivation, which counts how many redundant sign bits the operand carries.

A high/low select places the operand in the upper or lower half of the 32-bit field. An OR control merges the new shifted value into the previous result. With it, two 16-bit halves of a 32-bit word can be normalized or shifted in two consecutive operations.

A block-exponent register follows a group of derived exponents. It keeps the one of smallest magnitude, which is the value with the fewest redundant sign bits. Software reads it once a whole block has been scanned, and uses it to scale every element of the block by the same amount. A clear input restarts the tracking.

All three outputs are registered. An operation sampled on a rising clock edge with `op_valid` high shows its effect on the outputs right after that edge.

Top module: `bsh_norm_shifter`

## Requirements
- R1: While reset is applied and until the first operation, `result` reads 0, `exp_out` reads 0 and `blk_exp` reads -15 (0xF1).
- R2: With `hi_sel`=1 the operand sits in bits 31:16 of the field, and bits 15:0 are zero. With `hi_sel`=0 it sits in bits 15:0. The upper half is then zero for op codes 0, 2 and 3, and a copy of operand bit 15 for op code 1.
- R3: Op code 0 (logical) and op code 1 (arithmetic) shift the placed field by the two's-complement `shamt`: positive shifts left and negative shifts right. The result appears on the edge that samples the operation. A left shift fills with zeros. A right shift fills with zeros for op code 0 and with bit 31 of the placed field for op code 1.
- R4: A count of 32 or more gives an all-zero result. A count of -32 or less gives 32 copies of the right-shift fill bit.
- R5: Op code 4 stores, and shows on `exp_out`, the negative of the operand's redundant-sign-bit count. The count is the number of bits below bit 15 that match bit 15 before the first one that differs, so 0x0000 and 0xFFFF give -15. `result` is unchanged.
- R6: Op code 2 shifts the placed field left by the negated stored exponent.
- R7: Op code 3 shifts the placed field by the stored exponent, so a negative exponent shifts right. It fills with bit 31 of the placed field.
- R8: With `or_prev`=1, a shift operation writes the bitwise OR of the previous result and the new shifted value. With `or_prev`=0 it writes the shifted value alone.
- R9: On op code 4, `blk_exp` becomes the larger (signed) of itself and the new exponent. `blk_clr` alone sets it to -15, whether or not `op_valid` is high. `blk_clr` together with op code 4 sets it to the new exponent.
- R10: With `op_valid`=0, or with op codes 5 to 7, `result` and `exp_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation enable |
| op | input | 3 | Operation code (0 logical, 1 arithmetic, 2 normalize, 3 denormalize, 4 derive exponent) |
| din | input | 16 | Operand |
| shamt | input | 8 | Signed shift count for op codes 0 and 1 |
| hi_sel | input | 1 | Place the operand in the high half when 1 |
| or_prev | input | 1 | OR the new value into the previous result |
| blk_clr | input | 1 | Restart block-exponent tracking |
| result | output | 32 | Shifted result field |
| exp_out | output | 8 | Stored exponent, two's complement |
| blk_exp | output | 8 | Block exponent, two's complement |

## Verification
A wrong stored exponent shows on `exp_out` one edge after the derive operation. It also corrupts the very next normalize or denormalize result, so the same fault appears at two ports. A fault in the block-exponent register shows on `blk_exp` at the next edge, and it stays there until the next clear, because the register only moves upward. A bad OR merge or a bad fill bit stays in `result` until an operation with `or_prev` low overwrites it. For that reason the bench compares all three outputs against its own model on every clock.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic [2:0] {
    BSH_LSH    = 3'd0,
    BSH_ASH    = 3'd1,
    BSH_NORM   = 3'd2,
    BSH_DENORM = 3'd3,
    BSH_EXP    = 3'd4
  } bsh_op_e;
endpackage

// File: rtl/bsh_place.sv
// Puts the operand into the double-width field.
module bsh_place #(
  parameter int DATA_W = 16,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] din,
  input  logic              hi_sel,
  input  logic              sext,
  output logic [RES_W-1:0]  placed
);
  always_comb begin
    if (hi_sel) begin
      placed = {din, {DATA_W{1'b0}}};
    end else if (sext) begin
      placed = {{DATA_W{din[DATA_W-1]}}, din};
    end else begin
      placed = {{DATA_W{1'b0}}, din};
    end
  end
endmodule

// File: rtl/bsh_barrel.sv
// Log-stage barrel with a signed count; saturates beyond the field width.
module bsh_barrel #(
  parameter int RES_W = 32,
  parameter int CNT_W = 8,
  localparam int SH_W = $clog2(RES_W)
) (
  input  logic [RES_W-1:0] data,
  input  logic             fill,
  input  logic [CNT_W-1:0] cnt,
  output logic [RES_W-1:0] shifted
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RES_W);

  logic             neg;
  logic [CNT_W-1:0] mag;
  logic             too_far;
  logic [RES_W-1:0] lst [SH_W+1];
  logic [RES_W-1:0] rst [SH_W+1];

  assign neg     = cnt[CNT_W-1];
  assign mag     = neg ? (CNT_W'(0) - cnt) : cnt;
  assign too_far = (mag >= LIMIT);
  assign lst[0]  = data;
  assign rst[0]  = data;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int S = 1 << i;
    assign lst[i+1] = mag[i] ? {lst[i][RES_W-1-S:0], {S{1'b0}}} : lst[i];
    assign rst[i+1] = mag[i] ? {{S{fill}}, rst[i][RES_W-1:S]} : rst[i];
  end

  always_comb begin
    if (too_far) begin
      shifted = neg ? {RES_W{fill}} : '0;
    end else begin
      shifted = neg ? rst[SH_W] : lst[SH_W];
    end
  end
endmodule

// File: rtl/bsh_expdet.sv
// Counts redundant sign bits and returns their negation.
module bsh_expdet #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic [DATA_W-1:0] din,
  output logic [CNT_W-1:0]  exp_val
);
  logic [CNT_W-1:0] rsb;
  logic             run;

  always_comb begin
    rsb = '0;
    run = 1'b1;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (run && (din[i] == din[DATA_W-1])) begin
        rsb = rsb + CNT_W'(1);
      end else begin
        run = 1'b0;
      end
    end
    exp_val = CNT_W'(0) - rsb;
  end
endmodule

// File: rtl/bsh_norm_shifter.sv
module bsh_norm_shifter
  import bsh_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  shamt,
  input  logic              hi_sel,
  input  logic              or_prev,
  input  logic              blk_clr,
  output logic [RES_W-1:0]  result,
  output logic [CNT_W-1:0]  exp_out,
  output logic [CNT_W-1:0]  blk_exp
);
  localparam logic [CNT_W-1:0] EXP_MIN = CNT_W'(1 - DATA_W);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  bsh_op_e          op_e;
  logic             sext;
  logic             fill;
  logic [RES_W-1:0] placed;
  logic [RES_W-1:0] shifted;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] exp_new;

  logic [RES_W-1:0] result_q, result_d;
  logic [CNT_W-1:0] exp_q, exp_d;
  logic [CNT_W-1:0] blk_q, blk_d;
  logic             res_en, exp_en, blk_en;

  assign op_e = bsh_op_e'(op);
  assign sext = (op_e == BSH_ASH);

  bsh_place #(.DATA_W(DATA_W)) u_place (
    .din    (din),
    .hi_sel (hi_sel),
    .sext   (sext),
    .placed (placed)
  );

  assign fill = (op_e != BSH_LSH) && placed[RES_W-1];

  always_comb begin
    case (op_e)
      BSH_NORM:   cnt = CNT_W'(0) - exp_q;
      BSH_DENORM: cnt = exp_q;
      default:    cnt = shamt;
    endcase
  end

  bsh_barrel #(.RES_W(RES_W), .CNT_W(CNT_W)) u_barrel (
    .data    (placed),
    .fill    (fill),
    .cnt     (cnt),
    .shifted (shifted)
  );

  bsh_expdet #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_expdet (
    .din     (din),
    .exp_val (exp_new)
  );

  // next-state logic
  always_comb begin
    res_en   = op_valid && (op <= 3'd3);
    exp_en   = op_valid && (op_e == BSH_EXP);
    blk_en   = exp_en || blk_clr;
    result_d = or_prev ? (result_q | shifted) : shifted;
    exp_d    = exp_new;
    if (exp_en) begin
      if (blk_clr || ($signed(exp_new) > $signed(blk_q))) blk_d = exp_new;
      else                                                 blk_d = blk_q;
    end else begin
      blk_d = EXP_MIN;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      result_q <= '0;
      exp_q    <= '0;
      blk_q    <= EXP_MIN;
    end else begin
      if (res_en) result_q <= result_d;
      if (exp_en) exp_q    <= exp_d;
      if (blk_en) blk_q    <= blk_d;
    end
  end

  assign result  = result_q;
  assign exp_out = exp_q;
  assign blk_exp = blk_q;
endmodule

// File: rtl/bsh_norm_shifter_chk.sv
module bsh_norm_shifter_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int RES_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op,
  input logic              or_prev,
  input logic              blk_clr,
  input logic [RES_W-1:0]  result,
  input logic [CNT_W-1:0]  exp_out,
  input logic [CNT_W-1:0]  blk_exp
);
  localparam logic [CNT_W-1:0] EXP_MIN = CNT_W'(1 - DATA_W);

  p_exp_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(exp_out) <= 0) && ($signed(exp_out) >= $signed(EXP_MIN)));

  p_blk_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(blk_exp) <= 0) && ($signed(blk_exp) >= $signed(EXP_MIN)));

  p_blk_no_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_clr |=> ($signed(blk_exp) >= $signed($past(blk_exp))));

  p_blk_ge_exp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == 3'd4) |=> ($signed(blk_exp) >= $signed(exp_out)));

  p_exp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op == 3'd4) |=> $stable(exp_out));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op > 3'd4) |=> $stable(result));

  p_exp_keeps_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == 3'd4) |=> $stable(result));

  p_or_keeps_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op <= 3'd3 && or_prev) |=> ((result & $past(result)) == $past(result)));
endmodule

bind bsh_norm_shifter bsh_norm_shifter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op       (op),
  .or_prev  (or_prev),
  .blk_clr  (blk_clr),
  .result   (result),
  .exp_out  (exp_out),
  .blk_exp  (blk_exp)
);

// File: tb/tb_bsh_norm_shifter.sv
`timescale 1ns/1ps
module tb_bsh_norm_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] din = 16'h0;
  logic [7:0]  shamt = 8'h0;
  logic        hi_sel = 1'b0;
  logic        or_prev = 1'b0;
  logic        blk_clr = 1'b0;
  logic [31:0] result;
  logic [7:0]  exp_out;
  logic [7:0]  blk_exp;

  int n_checks = 0;
  int n_fail   = 0;
  bit chk_en   = 1'b0;
  string cur_req = "R1";
  string m_tag   = "R1";

  logic [31:0] m_res = 32'h0;
  int          m_exp = 0;
  int          m_blk = -15;

  always #2.5 clk = ~clk;

  bsh_norm_shifter dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .din(din),
    .shamt(shamt), .hi_sel(hi_sel), .or_prev(or_prev), .blk_clr(blk_clr),
    .result(result), .exp_out(exp_out), .blk_exp(blk_exp)
  );

  function automatic logic [31:0] ref_place(logic [15:0] d, bit hi, bit sx);
    if (hi) return {d, 16'h0};
    if (sx && d[15]) return {16'hFFFF, d};
    return {16'h0, d};
  endfunction

  function automatic logic [31:0] ref_shift(logic [31:0] v, bit f, int c);
    logic [31:0] r = v;
    if (c >= 32) return 32'h0;
    if (c <= -32) return f ? 32'hFFFF_FFFF : 32'h0;
    if (c >= 0) return v << c;
    for (int k = 0; k < -c; k++) r = {f, r[31:1]};
    return r;
  endfunction

  function automatic int ref_rsb(logic [15:0] d);
    int n = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) break;
      n++;
    end
    return n;
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_res = 32'h0; m_exp = 0; m_blk = -15;
    end else begin
      logic [31:0] pl;
      logic [31:0] sh;
      int c;
      int e;
      bit f;
      m_tag = cur_req;
      if (op_valid && op <= 3'd3) begin
        pl = ref_place(din, hi_sel, op == 3'd1);
        f  = (op != 3'd0) && pl[31];
        if (op == 3'd2) c = -m_exp;
        else if (op == 3'd3) c = m_exp;
        else c = $signed(shamt);
        sh = ref_shift(pl, f, c);
        m_res = or_prev ? (m_res | sh) : sh;
      end
      if (op_valid && op == 3'd4) begin
        e = -ref_rsb(din);
        m_exp = e;
        m_blk = (blk_clr || e > m_blk) ? e : m_blk;
      end else if (blk_clr) begin
        m_blk = -15;
      end
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check(m_tag, "result", result, m_res);
      check(m_tag, "exp_out", $signed(exp_out), m_exp);
      check(m_tag, "blk_exp", $signed(blk_exp), m_blk);
    end
  end

  task automatic issue(input logic [2:0] o, input logic [15:0] d, input int c,
                       input bit hi, input bit orp, input bit clr, input bit v,
                       input string tag);
    @(negedge clk);
    cur_req = tag; op_valid = v; op = o; din = d; shamt = c[7:0];
    hi_sel = hi; or_prev = orp; blk_clr = clr;
  endtask

  task automatic idle(input string tag);
    issue(3'd0, 16'h0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: values after reset
    check("R1", "result", result, 0);
    check("R1", "exp_out", exp_out, 0);
    check("R1", "blk_exp", blk_exp, 8'hF1);
    chk_en = 1'b1;

    // R2: placement
    issue(3'd0, 16'h8001, 0, 1, 0, 0, 1, "R2");
    issue(3'd0, 16'h8001, 0, 0, 0, 0, 1, "R2");
    issue(3'd1, 16'h8001, 0, 0, 0, 0, 1, "R2");
    issue(3'd1, 16'h7001, 0, 0, 0, 0, 1, "R2");
    // R3: signed shifts
    issue(3'd0, 16'h8421, 4, 0, 0, 0, 1, "R3");
    issue(3'd0, 16'h8421, -4, 1, 0, 0, 1, "R3");
    issue(3'd1, 16'h8421, -4, 1, 0, 0, 1, "R3");
    issue(3'd1, 16'h9001, -7, 0, 0, 0, 1, "R3");
    issue(3'd1, 16'h4001, 31, 0, 0, 0, 1, "R3");
    issue(3'd0, 16'hFFFF, -31, 1, 0, 0, 1, "R3");
    // R4: saturating counts
    issue(3'd0, 16'hFFFF, 32, 0, 0, 0, 1, "R4");
    issue(3'd1, 16'h8000, -32, 1, 0, 0, 1, "R4");
    issue(3'd1, 16'h8000, -128, 0, 0, 0, 1, "R4");
    issue(3'd0, 16'h8000, -40, 1, 0, 0, 1, "R4");
    issue(3'd1, 16'h7FFF, 127, 1, 0, 0, 1, "R4");
    issue(3'd1, 16'h7FFF, -33, 1, 0, 0, 1, "R4");
    // R5 and R9: exponents and block tracking
    issue(3'd0, 16'h0, 0, 0, 0, 1, 0, "R9");
    issue(3'd4, 16'h0000, 0, 1, 0, 0, 1, "R5");
    issue(3'd4, 16'hFFFF, 0, 1, 0, 0, 1, "R5");
    issue(3'd4, 16'h0001, 0, 1, 0, 0, 1, "R5");
    issue(3'd4, 16'h1234, 0, 1, 0, 0, 1, "R5");
    issue(3'd4, 16'hFF00, 0, 1, 0, 0, 1, "R9");
    issue(3'd4, 16'h8000, 0, 1, 0, 0, 1, "R5");
    issue(3'd4, 16'h4000, 0, 1, 0, 0, 1, "R9");
    issue(3'd4, 16'h0F00, 0, 1, 0, 1, 1, "R9");
    issue(3'd4, 16'h00F0, 0, 1, 0, 0, 1, "R9");
    issue(3'd5, 16'h0, 0, 0, 0, 1, 1, "R9");
    // R6: normalize a 32-bit value split in two words
    issue(3'd4, 16'h0123, 0, 1, 0, 0, 1, "R6");
    issue(3'd2, 16'h0123, 0, 1, 0, 0, 1, "R6");
    issue(3'd2, 16'hABCD, 0, 0, 1, 0, 1, "R6");
    issue(3'd4, 16'hFC10, 0, 1, 0, 0, 1, "R6");
    issue(3'd2, 16'hFC10, 0, 1, 0, 0, 1, "R6");
    // R7: denormalize
    issue(3'd3, 16'hC000, 0, 1, 0, 0, 1, "R7");
    issue(3'd3, 16'h8F00, 0, 0, 1, 0, 1, "R7");
    issue(3'd4, 16'h0000, 0, 1, 0, 0, 1, "R7");
    issue(3'd3, 16'h8001, 0, 1, 0, 0, 1, "R7");
    // R8: OR merge
    issue(3'd0, 16'h00F0, 8, 1, 0, 0, 1, "R8");
    issue(3'd0, 16'h0F00, -4, 0, 1, 0, 1, "R8");
    issue(3'd1, 16'h8000, -20, 1, 1, 0, 1, "R8");
    issue(3'd0, 16'h0001, 0, 0, 0, 0, 1, "R8");
    // R10: ignored operations
    issue(3'd4, 16'h3000, 0, 1, 0, 0, 0, "R10");
    issue(3'd0, 16'hFFFF, 3, 1, 1, 0, 0, "R10");
    issue(3'd6, 16'hFFFF, 3, 1, 0, 0, 1, "R10");
    issue(3'd7, 16'h1234, -3, 0, 0, 0, 1, "R10");
    issue(3'd5, 16'h0000, 0, 1, 0, 0, 1, "R10");
    idle("R10");
    // mixed traffic
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r = $urandom;
      issue(3'(r[2:0] % 3'd6 == 3'd5 ? 3'd4 : r[2:0]), 16'($urandom),
            int'($signed(r[15:8])), r[16], r[17], r[18] & r[19], r[20] | r[21], "R3");
    end
    idle("R10");
    idle("R10");
    @(negedge clk);
    chk_en = 1'b0;
    finish_run();
  end
endmodule